// File: doc/BRIEF.md
# Superscalar Issue Group Former

This block looks at the four oldest entries of a decoded instruction buffer each cycle. It decides how many of them, taken strictly in program order, can leave together as one issue group. Each entry carries a valid bit, a 4-bit class code and two flags. The `solo` flag means the instruction must issue alone. The `brk` flag means nothing younger may join its group. The block returns three results: the number of entries that issue, a mask of the issuing lanes, and the issue slot given to each of them. When nothing can issue it raises a stall.

The entry valid bits act as the stream's valid. The returned count acts as the ready/pop: the buffer removes exactly `grp_cnt` entries from its head. A lane that is valid but not counted is back-pressured and is offered again on a later cycle. The block adds no other handshake. Results are registered and appear one clock after the inputs are applied.

Class codes: 0 no-op, 1 integer (either unit), 2 shift, 3 condition-code setter, 4 FP multiply/divide, 5 FP other, 6 branch, 7 load, 8 store, 9 call, 10 indirect jump-and-link, 11 FP compare, 12 register-conditional branch. Codes 13 to 15 behave as no-op.

Top module: `issue_group_former`

## Requirements
- R1: Grouping is in order. The first lane that is invalid or cannot join ends the group, and no later lane is considered. `grp_mask` is the lowest `grp_cnt` lanes. Results appear one clock after the inputs.
- R2: When lane 0 is invalid, `grp_cnt` is 0. `grp_stall` is 1 exactly when `grp_cnt` is 0.
- R3: A group holds at most one shift (class 2), the only class that needs integer unit 0.
- R4: A group holds at most one instruction that needs integer unit 1: classes 3, 9, 10, 11 and 12.
- R5: FP and branch classes (4, 5, 6, 12) take slot 3, which is `grp_slot` bits [2i+1:2i] = 3 for lane i. Such an instruction is the last one in its group.
- R6: A group holds at most one memory-port user: classes 7, 8 and 10.
- R7: A lane with `solo` set issues only as the first lane, and always alone.
- R8: Call (9), jump-and-link (10) and any lane with `brk` set end the group after themselves.
- R9: A group holds at most two integer register writers: classes 1, 2, 3, 7, 9 and 10.
- R10: An unpinned lane gets the slot equal to its position in the group. Integer and memory classes (1, 2, 3, 7, 8, 9, 10, 11) cannot take slot 3; only a no-op can. Lanes that do not issue report slot 0.
- R11: After reset, `grp_cnt` is 0, `grp_mask` is 0 and `grp_stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_vld | input | 4 | Valid bit per buffer lane, lane 0 oldest |
| head_cls | input | 16 | Class code per lane, lane i at bits [4i+3:4i] |
| head_solo | input | 4 | Must-issue-alone flag per lane |
| head_brk | input | 4 | End-group-after flag per lane |
| grp_cnt | output | 3 | Number of lanes issuing (pop count) |
| grp_mask | output | 4 | Issuing lanes |
| grp_slot | output | 8 | Issue slot per lane, lane i at bits [2i+1:2i] |
| grp_stall | output | 1 | No lane issues this cycle |

## Verification
All three results and the stall come from one register stage, so each is due on the first rising edge after a stimulus is applied. The bench drives a stimulus on a falling edge. It reads all outputs on the next falling edge, half a cycle after they update and before the next stimulus. This applies to the table of hand-computed groups, the directed reset and invalid-head cases, and the random class mixes checked against an in-bench model of the grouping rules. The reset check reads the outputs while reset is held, before the first stimulus.

// File: rtl/igf_pkg.sv
package igf_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    IC_NOP   = 4'd0,
    IC_ALU   = 4'd1,
    IC_SHIFT = 4'd2,
    IC_CCSET = 4'd3,
    IC_FMUL  = 4'd4,
    IC_FADD  = 4'd5,
    IC_BR    = 4'd6,
    IC_LOAD  = 4'd7,
    IC_STORE = 4'd8,
    IC_CALL  = 4'd9,
    IC_JLINK = 4'd10,
    IC_FCMP  = 4'd11,
    IC_BRREG = 4'd12
  } iclass_e;

  // Resource needs of one decoded lane
  typedef struct packed {
    logic pin_last;   // must take the last slot
    logic low_only;   // restricted to slots below the last
    logic use_u0;     // integer unit 0
    logic use_u1;     // integer unit 1
    logic use_ls;     // memory port
    logic int_wr;     // integer register write port
    logic ends_grp;   // nothing younger joins
  } ires_t;
endpackage

// File: rtl/igf_lane_decode.sv
module igf_lane_decode
  import igf_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             brk,
  output ires_t            res
);
  always_comb begin
    res = '0;
    unique case (cls)
      IC_ALU:   begin res.low_only = 1'b1; res.int_wr = 1'b1; end
      IC_SHIFT: begin res.low_only = 1'b1; res.use_u0 = 1'b1; res.int_wr = 1'b1; end
      IC_CCSET: begin res.low_only = 1'b1; res.use_u1 = 1'b1; res.int_wr = 1'b1; end
      IC_FMUL,
      IC_FADD,
      IC_BR:    res.pin_last = 1'b1;
      IC_BRREG: begin res.pin_last = 1'b1; res.use_u1 = 1'b1; end
      IC_LOAD:  begin res.low_only = 1'b1; res.use_ls = 1'b1; res.int_wr = 1'b1; end
      IC_STORE: begin res.low_only = 1'b1; res.use_ls = 1'b1; end
      IC_CALL:  begin res.low_only = 1'b1; res.use_u1 = 1'b1; res.int_wr = 1'b1;
                      res.ends_grp = 1'b1; end
      IC_JLINK: begin res.low_only = 1'b1; res.use_u1 = 1'b1; res.use_ls = 1'b1;
                      res.int_wr = 1'b1; res.ends_grp = 1'b1; end
      IC_FCMP:  begin res.low_only = 1'b1; res.use_u1 = 1'b1; end
      default:  res = '0;
    endcase
    if (brk) res.ends_grp = 1'b1;
  end
endmodule

// File: rtl/igf_chain.sv
module igf_chain
  import igf_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_IWR = 2,
  localparam int SLOT_W = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]             vld,
  input  logic [LANES-1:0]             solo,
  input  ires_t [LANES-1:0]            res,
  output logic [LANES-1:0]             iss,
  output logic [CNT_W-1:0]             cnt,
  output logic [LANES-1:0][SLOT_W-1:0] slot
);
  localparam int LAST = LANES - 1;

  always_comb begin
    int  pos, n_u0, n_u1, n_ls, n_iw;
    logic done, fit;
    pos = 0; n_u0 = 0; n_u1 = 0; n_ls = 0; n_iw = 0;
    done = 1'b0;
    iss  = '0;
    slot = '0;
    for (int j = 0; j < LANES; j++) begin
      fit = vld[j] && !done;
      if (solo[j] && pos != 0)                            fit = 1'b0;
      if (!res[j].pin_last && res[j].low_only && pos >= LAST) fit = 1'b0;
      if (res[j].use_u0 && n_u0 != 0)                     fit = 1'b0;
      if (res[j].use_u1 && n_u1 != 0)                     fit = 1'b0;
      if (res[j].use_ls && n_ls != 0)                     fit = 1'b0;
      if (res[j].int_wr && n_iw >= MAX_IWR)               fit = 1'b0;
      if (fit) begin
        iss[j]  = 1'b1;
        slot[j] = res[j].pin_last ? SLOT_W'(LAST) : SLOT_W'(pos);
        pos  = pos + 1;
        n_u0 = n_u0 + int'(res[j].use_u0);
        n_u1 = n_u1 + int'(res[j].use_u1);
        n_ls = n_ls + int'(res[j].use_ls);
        n_iw = n_iw + int'(res[j].int_wr);
        if (solo[j] || res[j].ends_grp || res[j].pin_last) done = 1'b1;
      end else begin
        done = 1'b1;
      end
    end
    cnt = CNT_W'(pos);
  end
endmodule

// File: rtl/issue_group_former.sv
module issue_group_former
  import igf_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_IWR = 2,
  localparam int SLOT_W = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          head_vld,
  input  logic [LANES*CLS_W-1:0]    head_cls,
  input  logic [LANES-1:0]          head_solo,
  input  logic [LANES-1:0]          head_brk,
  output logic [CNT_W-1:0]          grp_cnt,
  output logic [LANES-1:0]          grp_mask,
  output logic [LANES*SLOT_W-1:0]   grp_slot,
  output logic                      grp_stall
);
  ires_t [LANES-1:0]             lane_res;
  logic  [LANES-1:0]             c_iss;
  logic  [CNT_W-1:0]             c_cnt;
  logic  [LANES-1:0][SLOT_W-1:0] c_slot;
  logic  [LANES-1:0]             u0_v, u1_v, ls_v, iw_v, pin_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    igf_lane_decode u_dec (
      .cls (head_cls[g*CLS_W +: CLS_W]),
      .brk (head_brk[g]),
      .res (lane_res[g])
    );
    assign u0_v[g]  = lane_res[g].use_u0;
    assign u1_v[g]  = lane_res[g].use_u1;
    assign ls_v[g]  = lane_res[g].use_ls;
    assign iw_v[g]  = lane_res[g].int_wr;
    assign pin_v[g] = lane_res[g].pin_last;
  end

  igf_chain #(.LANES(LANES), .MAX_IWR(MAX_IWR)) u_chain (
    .vld  (head_vld),
    .solo (head_solo),
    .res  (lane_res),
    .iss  (c_iss),
    .cnt  (c_cnt),
    .slot (c_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_cnt   <= '0;
      grp_mask  <= '0;
      grp_slot  <= '0;
      grp_stall <= 1'b1;
    end else begin
      grp_cnt   <= c_cnt;
      grp_mask  <= c_iss;
      grp_slot  <= c_slot;
      grp_stall <= !head_vld[0];
    end
  end

  // Registered result consistency
  assert_stall_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_stall == (grp_cnt == '0));
  assert_head_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld[0] |=> grp_stall);
  assert_mask_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask == LANES'((1 << grp_cnt) - 1));
  // Unit and port exclusivity on the chosen group
  assert_one_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(c_iss & u0_v) <= 1);
  assert_one_u1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(c_iss & u1_v) <= 1);
  assert_one_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(c_iss & ls_v) <= 1);
  assert_int_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(c_iss & iw_v) <= MAX_IWR);
  assert_solo_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(c_iss & head_solo)) |-> (c_iss == LANES'(1)));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_pin_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_iss[g] && pin_v[g]) |-> (c_slot[g] == SLOT_W'(LANES - 1)));
    if (g < LANES - 1) begin : g_tail
      assert_pin_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_iss[g] && pin_v[g]) |-> !c_iss[g+1]);
    end
  end
endmodule

// File: tb/issue_group_former_tb_top.sv
module issue_group_former_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  head_vld = '0;
  logic [15:0] head_cls = '0;
  logic [3:0]  head_solo = '0;
  logic [3:0]  head_brk = '0;
  logic [2:0]  grp_cnt;
  logic [3:0]  grp_mask;
  logic [7:0]  grp_slot;
  logic        grp_stall;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  issue_group_former dut_i (
    .clk, .rst_n, .head_vld, .head_cls, .head_solo, .head_brk,
    .grp_cnt, .grp_mask, .grp_slot, .grp_stall
  );

  // {vld, cls lane3..lane0, solo, brk, expected count, expected slots}
  localparam int NV = 16;
  localparam logic [38:0] TBL [NV] = '{
    {4'hF, 4'h1, 4'h1, 4'h1, 4'h1, 4'h0, 4'h0, 3'd2, 8'h04}, // R9 writes
    {4'hF, 4'h1, 4'h1, 4'h2, 4'h2, 4'h0, 4'h0, 3'd1, 8'h00}, // R3 shifts
    {4'hF, 4'h1, 4'h1, 4'hB, 4'h3, 4'h0, 4'h0, 3'd1, 8'h00}, // R4 cc+fcmp
    {4'hF, 4'h0, 4'h1, 4'h4, 4'h1, 4'h0, 4'h0, 3'd2, 8'h0C}, // R5 fp ends
    {4'hF, 4'h1, 4'h1, 4'h8, 4'h7, 4'h0, 4'h0, 3'd1, 8'h00}, // R6 ld+st
    {4'hF, 4'h5, 4'h0, 4'h0, 4'h7, 4'h0, 4'h0, 3'd4, 8'hE4}, // R10 full
    {4'hF, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 3'd3, 8'h24}, // R10 ld not slot3
    {4'hF, 4'h0, 4'h0, 4'h1, 4'h1, 4'h2, 4'h0, 3'd1, 8'h00}, // R7 solo late
    {4'hF, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 3'd1, 8'h00}, // R7 solo first
    {4'hF, 4'h0, 4'h0, 4'h0, 4'h9, 4'h0, 4'h0, 3'd1, 8'h00}, // R8 call
    {4'hF, 4'h6, 4'h8, 4'h3, 4'h2, 4'h0, 4'h0, 3'd4, 8'hE4}, // R5 branch slot3
    {4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 3'd2, 8'h04}, // R1 valid gap
    {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 3'd1, 8'h00}, // R8 brk flag
    {4'hF, 4'h0, 4'h0, 4'hC, 4'h3, 4'h0, 4'h0, 3'd1, 8'h00}, // R4 reg branch
    {4'hF, 4'h0, 4'h0, 4'hA, 4'h7, 4'h0, 4'h0, 3'd1, 8'h00}, // R6 jlink mem
    {4'hF, 4'h0, 4'h1, 4'h1, 4'hB, 4'h0, 4'h0, 3'd4, 8'hE4}  // R10 nop slot3
  };

  // Reference model of the grouping rules
  task automatic model(input logic [3:0] v, input logic [15:0] c,
                       input logic [3:0] s, input logic [3:0] b,
                       output logic [2:0] n, output logic [7:0] sl);
    int u0 = 0, u1 = 0, ls = 0, iw = 0;
    bit stop = 0;
    n = 0; sl = 0;
    for (int k = 0; k < 4; k++) begin
      int cc = int'(c[4*k +: 4]);
      bit pin  = (cc == 4 || cc == 5 || cc == 6 || cc == 12);
      bit low  = (cc >= 1 && cc <= 3) || (cc >= 7 && cc <= 11);
      bit a0   = (cc == 2);
      bit a1   = (cc == 3 || cc == 9 || cc == 10 || cc == 11 || cc == 12);
      bit am   = (cc == 7 || cc == 8 || cc == 10);
      bit aw   = (cc == 1 || cc == 2 || cc == 3 || cc == 7 || cc == 9 || cc == 10);
      bit ends = (cc == 9 || cc == 10 || b[k] || s[k] || pin);
      if (stop || !v[k]) begin stop = 1; continue; end
      if ((s[k] && n != 0) || (low && n == 3) || (a0 && u0 > 0) ||
          (a1 && u1 > 0) || (am && ls > 0) || (aw && iw >= 2)) begin
        stop = 1; continue;
      end
      sl[2*k +: 2] = pin ? 2'd3 : 2'(n);
      n = n + 3'd1;
      u0 += int'(a0); u1 += int'(a1); ls += int'(am); iw += int'(aw);
      if (ends) stop = 1;
    end
  endtask

  task automatic check_out(input string tag, input logic [2:0] en,
                           input logic [7:0] es);
    logic [3:0] em;
    em = 4'((5'd1 << en) - 5'd1);
    checks++;
    if (grp_cnt !== en || grp_slot !== es || grp_mask !== em ||
        grp_stall !== (en == 0)) begin
      errors++;
      $display("FAIL %s: cnt=%0d slot=%h mask=%b stall=%b expected cnt=%0d slot=%h mask=%b stall=%b",
               tag, grp_cnt, grp_slot, grp_mask, grp_stall, en, es, em, (en == 0));
    end
  endtask

  task automatic apply(input logic [3:0] v, input logic [15:0] c,
                       input logic [3:0] s, input logic [3:0] b);
    @(negedge clk);
    head_vld = v; head_cls = c; head_solo = s; head_brk = b;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] mn;
    logic [7:0] ms;
    repeat (3) @(negedge clk);
    check_out("R11 reset", 3'd0, 8'h00);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][38:35], TBL[i][34:19], TBL[i][18:15], TBL[i][14:11]);
      check_out($sformatf("table %0d (R1 R3-R10)", i), TBL[i][10:8], TBL[i][7:0]);
    end

    // R2: head invalid, later lanes valid
    apply(4'hE, 16'h1111, 4'h0, 4'h0);
    check_out("R2 head invalid", 3'd0, 8'h00);
    apply(4'h0, 16'h0000, 4'h0, 4'h0);
    check_out("R2 empty", 3'd0, 8'h00);
    // R1: gap in valid bits stops the group
    apply(4'hD, 16'h0000, 4'h0, 4'h0);
    check_out("R1 gap at lane1", 3'd1, 8'h00);

    // Random class mixes against the model
    for (int r = 0; r < 600; r++) begin
      logic [3:0] v, s, b;
      logic [15:0] c;
      v = 4'($urandom);
      if ($urandom_range(0, 7) != 0) v[0] = 1'b1;
      c = 16'($urandom);
      s = 4'($urandom) & 4'($urandom) & 4'($urandom);
      b = 4'($urandom) & 4'($urandom) & 4'($urandom);
      model(v, c, s, b, mn, ms);
      apply(v, c, s, b);
      check_out("random R1-model", mn, ms);
    end

    // R11: reset in mid-run clears results
    apply(4'hF, 16'h0011, 4'h0, 4'h0);
    rst_n = 1'b0;
    #1;
    check_out("R11 reset mid-run", 3'd0, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule